// File: doc/BRIEF.md
# Leading-Zero-Byte Suppression Packer

This block shrinks vectors of four 32-bit integers by dropping the zero bytes at the top of each word. For every word it finds how many of its upper bytes are zero, records that count as a 2-bit length code, and keeps only the significant low bytes. The four codes form one descriptor byte. The kept bytes of all four words are packed back to back into a single payload with no gaps.

A vector arrives on a valid/ready input, one vector per beat. The result is held in an output register and is shown two ways at once. In parallel form it gives the descriptor, the payload length, the packed bytes and a byte-lane valid mask. In serial form it sends the descriptor byte first and then the payload bytes, one per accepted beat. While a held result is still being drained on the serial side, the input is stalled.

Top module: `zbp_packer`

## Requirements
- R1: Each word's 2-bit code is its number of leading zero bytes, from 0 to 3. An all-zero word is coded 3 and keeps one byte of value 0x00. A word whose top byte is nonzero, such as 0xFFFFFFFF, is coded 0.
- R2: The descriptor `pk_desc` carries the code of element 0 (`in_data[31:0]`) in bits 7:6, element 1 in bits 5:4, element 2 in bits 3:2 and element 3 in bits 1:0. For example, codes 3,2,1,0 give 8'hE4.
- R3: `pk_len` equals the sum over the four elements of (4 - code). It therefore lies between 4 and 16.
- R4: `pk_bytes` byte k (bits 8k+7:8k) holds the k-th kept byte. The kept bytes of each element are taken least significant first, the elements follow in input order, and there are no gaps. Byte lanes at or above `pk_len` read 0.
- R5: Bit k of `pk_mask` is 1 exactly when k < `pk_len`.
- R6: The serial stream first sends `pk_desc` and then the `pk_len` payload bytes in `pk_bytes` order. `st_last` is high on the final byte. A byte moves on only when `st_valid` and `st_ready` are both high, and while `st_ready` is low the byte stays unchanged.
- R7: While a result is held (`pk_valid` high), `in_ready` is low. During that time an input beat is ignored and the held outputs do not change.
- R8: After reset, `pk_valid` and `st_valid` are 0 and `in_ready` is 1.
- R9: A vector taken at a clock edge with `in_valid` and `in_ready` high appears on the outputs with `pk_valid` high from the next cycle. Once the final stream byte has been accepted, `pk_valid` falls and `in_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Block can take a vector |
| in_data | input | 128 | Four 32-bit elements, element 0 in bits 31:0 |
| pk_valid | output | 1 | Held result is valid |
| pk_desc | output | 8 | Descriptor of four 2-bit codes |
| pk_len | output | 5 | Payload length in bytes |
| pk_bytes | output | 128 | Packed payload, byte 0 in bits 7:0 |
| pk_mask | output | 16 | Byte-lane valid mask for pk_bytes |
| st_valid | output | 1 | Serial byte valid |
| st_data | output | 8 | Serial byte: descriptor, then payload |
| st_last | output | 1 | Final byte of the current result |
| st_ready | input | 1 | Downstream takes the serial byte |

## Verification
The bench builds the block with its default parameters, four lanes of four-byte words. With these values all four codes can occur in a single vector, and both the shortest payload (4 bytes, all words zero) and the longest (16 bytes, all top bytes set) can be reached. Mixed vectors place each element's kept bytes at different payload offsets, which tests the stitching across lane boundaries. Drains that are throttled, and input beats sent while a result is still being held, test the stall behaviour on both sides.

// File: rtl/zbp_pkg.sv
package zbp_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/zbp_lz_count.sv
module zbp_lz_count #(
  parameter int WORD_BYTES = 4,
  parameter int CW = $clog2(WORD_BYTES)
) (
  input  logic [WORD_BYTES*8-1:0] word_i,
  output logic [CW-1:0]           code_o
);
  always_comb begin
    int  cnt;
    logic stop;
    cnt  = 0;
    stop = 1'b0;
    for (int b = WORD_BYTES - 1; b >= 1; b--) begin
      if (!stop && word_i[b*8 +: 8] == 8'h00) cnt = cnt + 1;
      else stop = 1'b1;
    end
    code_o = CW'(cnt);
  end
endmodule

// File: rtl/zbp_stitch.sv
module zbp_stitch #(
  parameter int LANES = 4,
  parameter int WORD_BYTES = 4,
  localparam int CW = $clog2(WORD_BYTES),
  localparam int TOTAL = LANES * WORD_BYTES,
  localparam int LEN_W = $clog2(TOTAL + 1)
) (
  input  logic [TOTAL*8-1:0]  data_i,
  input  logic [LANES*CW-1:0] desc_i,
  output logic [TOTAL*8-1:0]  bytes_o,
  output logic [LEN_W-1:0]    len_o,
  output logic [TOTAL-1:0]    mask_o
);
  always_comb begin
    int off;
    int kept;
    bytes_o = '0;
    off     = 0;
    for (int i = 0; i < LANES; i++) begin
      kept = WORD_BYTES - int'(desc_i[(LANES-1-i)*CW +: CW]);
      for (int j = 0; j < WORD_BYTES; j++) begin
        if (j < kept) bytes_o[(off+j)*8 +: 8] = data_i[(i*WORD_BYTES+j)*8 +: 8];
      end
      off = off + kept;
    end
    len_o = LEN_W'(off);
    for (int k = 0; k < TOTAL; k++) mask_o[k] = (k < off);
  end
endmodule

// File: rtl/zbp_serializer.sv
module zbp_serializer
  import zbp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WORD_BYTES = 4,
  localparam int CW = $clog2(WORD_BYTES),
  localparam int DESC_W = LANES * CW,
  localparam int TOTAL = LANES * WORD_BYTES,
  localparam int LEN_W = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DESC_W-1:0] ld_desc_i,
  input  logic [LEN_W-1:0]  ld_len_i,
  input  logic [TOTAL*8-1:0] ld_bytes_i,
  input  logic [TOTAL-1:0]  ld_mask_i,
  output logic              busy_o,
  output logic [DESC_W-1:0] desc_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [TOTAL*8-1:0] bytes_o,
  output logic [TOTAL-1:0]  mask_o,
  output logic              st_valid_o,
  output byte_t             st_data_o,
  output logic              st_last_o,
  input  logic              st_ready_i
);
  logic             hold_valid;
  logic [LEN_W-1:0] idx;
  logic             fire;

  assign busy_o     = hold_valid;
  assign st_valid_o = hold_valid;
  assign st_last_o  = hold_valid && (idx == len_o);
  assign fire       = hold_valid && st_ready_i;

  always_comb begin
    if (idx == '0) st_data_o = byte_t'(desc_o);
    else           st_data_o = bytes_o[(int'(idx) - 1)*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      idx        <= '0;
      desc_o     <= '0;
      len_o      <= '0;
      bytes_o    <= '0;
      mask_o     <= '0;
    end else if (load_i && !hold_valid) begin
      hold_valid <= 1'b1;
      idx        <= '0;
      desc_o     <= ld_desc_i;
      len_o      <= ld_len_i;
      bytes_o    <= ld_bytes_i;
      mask_o     <= ld_mask_i;
    end else if (fire) begin
      if (st_last_o) begin
        hold_valid <= 1'b0;
        idx        <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/zbp_packer.sv
module zbp_packer
  import zbp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WORD_BYTES = 4,
  localparam int CW = $clog2(WORD_BYTES),
  localparam int DESC_W = LANES * CW,
  localparam int TOTAL = LANES * WORD_BYTES,
  localparam int LEN_W = $clog2(TOTAL + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TOTAL*8-1:0] in_data,
  output logic               pk_valid,
  output logic [DESC_W-1:0]  pk_desc,
  output logic [LEN_W-1:0]   pk_len,
  output logic [TOTAL*8-1:0] pk_bytes,
  output logic [TOTAL-1:0]   pk_mask,
  output logic               st_valid,
  output logic [7:0]         st_data,
  output logic               st_last,
  input  logic               st_ready
);
  logic [DESC_W-1:0]  desc_c;
  logic [TOTAL*8-1:0] bytes_c;
  logic [LEN_W-1:0]   len_c;
  logic [TOTAL-1:0]   mask_c;
  logic               busy;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    zbp_lz_count #(.WORD_BYTES(WORD_BYTES), .CW(CW)) lz_i (
      .word_i (in_data[i*WORD_BYTES*8 +: WORD_BYTES*8]),
      .code_o (desc_c[(LANES-1-i)*CW +: CW])
    );
  end

  zbp_stitch #(.LANES(LANES), .WORD_BYTES(WORD_BYTES)) stitch_i (
    .data_i  (in_data),
    .desc_i  (desc_c),
    .bytes_o (bytes_c),
    .len_o   (len_c),
    .mask_o  (mask_c)
  );

  zbp_serializer #(.LANES(LANES), .WORD_BYTES(WORD_BYTES)) ser_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (in_valid),
    .ld_desc_i  (desc_c),
    .ld_len_i   (len_c),
    .ld_bytes_i (bytes_c),
    .ld_mask_i  (mask_c),
    .busy_o     (busy),
    .desc_o     (pk_desc),
    .len_o      (pk_len),
    .bytes_o    (pk_bytes),
    .mask_o     (pk_mask),
    .st_valid_o (st_valid),
    .st_data_o  (st_data),
    .st_last_o  (st_last),
    .st_ready_i (st_ready)
  );

  assign pk_valid = busy;
  assign in_ready = !busy;
endmodule

// File: rtl/zbp_packer_chk.sv
module zbp_packer_chk #(
  parameter int LANES = 4,
  parameter int WORD_BYTES = 4,
  localparam int CW = $clog2(WORD_BYTES),
  localparam int DESC_W = LANES * CW,
  localparam int TOTAL = LANES * WORD_BYTES,
  localparam int LEN_W = $clog2(TOTAL + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              pk_valid,
  input logic [DESC_W-1:0] pk_desc,
  input logic [LEN_W-1:0]  pk_len,
  input logic [TOTAL-1:0]  pk_mask,
  input logic              st_valid,
  input logic [7:0]        st_data,
  input logic              st_last,
  input logic              st_ready
);
  assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> pk_valid);

  assert_done_R9: assert property (@(posedge clk) disable iff (rst)
    st_valid && st_ready && st_last |=> !pk_valid && in_ready);

  assert_busy_R7: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> !in_ready);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    pk_valid && !(st_ready && st_last) |=> pk_valid && $stable(pk_desc) && $stable(pk_len));

  assert_len_range_R3: assert property (@(posedge clk) disable iff (rst)
    pk_valid |-> (pk_len >= LEN_W'(LANES)) && (pk_len <= LEN_W'(TOTAL)));

  assert_mask_count_R5: assert property (@(posedge clk) disable iff (rst)
    pk_valid |-> $countones(pk_mask) == int'(pk_len));

  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last));
endmodule

bind zbp_packer zbp_packer_chk #(.LANES(LANES), .WORD_BYTES(WORD_BYTES)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .pk_valid (pk_valid),
  .pk_desc  (pk_desc),
  .pk_len   (pk_len),
  .pk_mask  (pk_mask),
  .st_valid (st_valid),
  .st_data  (st_data),
  .st_last  (st_last),
  .st_ready (st_ready)
);

// File: tb/zbp_packer_tb.sv
module zbp_packer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_data;
  logic         pk_valid;
  logic [7:0]   pk_desc;
  logic [4:0]   pk_len;
  logic [127:0] pk_bytes;
  logic [15:0]  pk_mask;
  logic         st_valid;
  logic [7:0]   st_data;
  logic         st_last;
  logic         st_ready;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zbp_packer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pk_valid(pk_valid), .pk_desc(pk_desc), .pk_len(pk_len), .pk_bytes(pk_bytes),
    .pk_mask(pk_mask), .st_valid(st_valid), .st_data(st_data), .st_last(st_last),
    .st_ready(st_ready)
  );

  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: code by byte tests, descriptor element 0 in top pair, payload LSB first.
  task automatic model(input logic [127:0] d, output logic [7:0] desc,
                       output logic [4:0] len, output logic [127:0] bytes);
    int pos = 0;
    bytes = '0;
    desc  = '0;
    for (int e = 0; e < 4; e++) begin
      logic [31:0] w;
      int code;
      w = d[e*32 +: 32];
      if (w[31:8] == 24'h0)       code = 3;
      else if (w[31:16] == 16'h0) code = 2;
      else if (w[31:24] == 8'h0)  code = 1;
      else                        code = 0;
      desc[(3-e)*2 +: 2] = 2'(code);
      for (int b = 0; b < 4 - code; b++) begin
        bytes[pos*8 +: 8] = w[b*8 +: 8];
        pos++;
      end
    end
    len = 5'(pos);
  endtask

  task automatic load(input logic [127:0] d);
    @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_parallel(input logic [127:0] d, input string tag);
    logic [7:0] ed; logic [4:0] el; logic [127:0] eb; logic [15:0] em;
    model(d, ed, el, eb);
    em = 16'((32'h1 << el) - 1);
    check(pk_valid === 1'b1, {"R9 valid ", tag}, 128'(pk_valid), 128'h1);
    check(in_ready === 1'b0, {"R7 ready low ", tag}, 128'(in_ready), 128'h0);
    check(pk_desc === ed, {"R1/R2 desc ", tag}, 128'(pk_desc), 128'(ed));
    check(pk_len === el, {"R3 len ", tag}, 128'(pk_len), 128'(el));
    check(pk_bytes === eb, {"R4 bytes ", tag}, pk_bytes, eb);
    check(pk_mask === em, {"R5 mask ", tag}, 128'(pk_mask), 128'(em));
  endtask

  task automatic drain(input logic [127:0] d, input logic throttle, input string tag);
    logic [7:0] ed; logic [4:0] el; logic [127:0] eb;
    model(d, ed, el, eb);
    for (int k = 0; k <= int'(el); k++) begin
      logic [7:0] eb8;
      eb8 = (k == 0) ? ed : eb[(k-1)*8 +: 8];
      if (throttle && (k % 2 == 0)) begin
        st_ready = 1'b0;
        @(negedge clk);
        check(st_valid === 1'b1 && st_data === eb8, {"R6 stall hold ", tag},
              128'(st_data), 128'(eb8));
      end
      st_ready = 1'b1;
      check(st_valid === 1'b1 && st_data === eb8, {"R6 stream byte ", tag},
            128'(st_data), 128'(eb8));
      check(st_last === (k == int'(el)), {"R6 last flag ", tag},
            128'(st_last), 128'(k == int'(el)));
      @(negedge clk);
    end
    st_ready = 1'b0;
    check(pk_valid === 1'b0 && in_ready === 1'b1, {"R9 released ", tag},
          128'({pk_valid, in_ready}), 128'h1);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; in_data = '0; st_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pk_valid === 1'b0 && st_valid === 1'b0 && in_ready === 1'b1, "R8 reset state",
          128'({pk_valid, st_valid, in_ready}), 128'h1);
  endtask

  task automatic t_vector(input logic [127:0] d, input logic throttle, input string tag);
    load(d);
    check_parallel(d, tag);
    drain(d, throttle, tag);
  endtask

  task automatic t_ignore_busy;
    logic [127:0] d1, d2;
    logic [7:0] ed; logic [4:0] el; logic [127:0] eb;
    d1 = {32'h00000001, 32'h00ABCDEF, 32'h00001234, 32'h80000000};
    d2 = {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF};
    model(d1, ed, el, eb);
    load(d1);
    in_data  = d2;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready === 1'b0, "R7 busy not ready", 128'(in_ready), 128'h0);
    check(pk_desc === ed && pk_len === el && pk_bytes === eb, "R7 held result unchanged",
          128'(pk_desc), 128'(ed));
    drain(d1, 1'b0, "ignore");
    @(negedge clk);
    check(pk_valid === 1'b0, "R7 ignored beat not loaded", 128'(pk_valid), 128'h0);
  endtask

  initial begin
    t_reset();
    // Mixed codes 3,2,1,0: descriptor E4, length 10 (R1, R2).
    t_vector({32'hFFFFFFFF, 32'h006E5A22, 32'h000055EF, 32'h00000025}, 1'b0, "mixed");
    // All-zero words: code 3 each, one 0x00 byte each, length 4 (R1, R3).
    t_vector(128'h0, 1'b0, "zeros");
    // All full words: code 0, length 16 (R3, R4).
    t_vector({32'hF1F2F3F4, 32'hE1E2E3E4, 32'hD1D2D3D4, 32'hC1C2C3C4}, 1'b0, "full");
    // Reversed order of codes and throttled drain (R4, R6).
    t_vector({32'h00000099, 32'h00008877, 32'h00665544, 32'h33221100}, 1'b1, "throttle");
    // Sparse pattern with interior zero bytes kept (R1, R4).
    t_vector({32'h01000000, 32'h00000000, 32'h00010000, 32'h00000100}, 1'b1, "interior");
    t_ignore_busy();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule